// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is a hardware master for the clause-22 management interface between a MAC and its PHYs. A requester presents a start strobe together with a read/write select, a 5-bit PHY address, a register address and 16 bits of write data. The block then runs one complete management frame. It generates the MDC clock from the system clock, drives MDIO through an output-enable for an external tristate pad, and samples the returned bits on reads.

Each frame opens with a synchronisation run of driven ones. A read sends a 16-bit header and then releases the line to collect the PHY's reply. A write sends a 32-bit word that carries the header, the turnaround pattern and the data, and then releases the line for two more clocks. The MDC divider is derived from two parameters: the system clock frequency and the maximum MDC frequency. A register address that does not fit in five bits is refused at once and does not touch the bus.

Top module: `mdio_master`

## Requirements
- R1: MDC rests low whenever no frame is running. While a frame runs, each MDC high phase lasts exactly MDC_HALF system cycles and each low phase lasts at least MDC_HALF, with MDC_HALF = ceil(SYS_CLK_HZ / (2*MDC_MAX_HZ)). With the defaults (25 MHz / 2.5 MHz) that is 5 cycles.
- R2: Every bus frame begins with 33 MDC cycles during which MDIO is driven to 1.
- R3: A read then drives 16 header bits, most significant first: bits 15:14 = 11, 13:12 = 01, 11:10 = 10, 9:5 = PHY address, 4:0 = register address.
- R4: After the read header, MDIO is released for 19 MDC cycles. Samples 0 and 1 are dropped, samples 2 to 17 form the result (most significant first), and sample 18 is dropped.
- R5: A write drives a 32-bit word after the synchronisation run, most significant first: bits 31:30 = 01, 29:28 = 01, 27:23 = PHY address, 22:18 = register address, 17:16 = 10, 15:0 = data.
- R6: After the 32 write bits, MDIO is released for exactly 2 more MDC cycles.
- R7: MDIO output data changes only while MDC is low, and it is stable across each rising edge. Read bits are captured in the last low-phase system cycle before MDC rises.
- R8: A request whose register address exceeds 31 produces no MDC edge and no MDIO drive. Done is high in the cycle after the request is sampled. A refused read returns 0xFFFF, and a refused write leaves the read data unchanged.
- R9: A start is accepted only while busy is low. Busy is high from the cycle after acceptance through the done cycle. Done is a single-cycle pulse, and a start while busy is ignored.
- R10: The MDIO output-enable is high only during the synchronisation run and the header or write bits. It is low in released slots and in idle.
- R11: The read data output changes only in the done cycle of a read, and holds its value until then.
- R12: For a valid request, done is high exactly 2*MDC_HALF*N cycles after the accepting clock edge, with N = 68 for reads and N = 67 for writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Start strobe for one transaction |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_phy | input | 5 | PHY address |
| req_reg | input | REG_ADDR_W | Register address (values above 31 are refused) |
| req_wdata | input | 16 | Data for a write |
| rsp_rdata | output | 16 | Result of the last completed read |
| rsp_busy | output | 1 | Transaction in progress |
| rsp_done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO pad output-enable |
| mdio_in | input | 1 | MDIO value seen at the pad |

## Verification
Each result has a fixed cycle position. Busy appears one clock after the accepting edge. Done comes on the next clock for a refused request, and 680 or 670 clocks after acceptance for a read or a write with the default divider. Read data and the end of busy follow the done cycle. The bench counts clocks on the falling system edge from the acceptance to the done pulse and compares the count with the figure the slot count gives. It records every driven bit and every released slot at each MDC rise. Its PHY model changes its reply only right after an MDC rise, so a correct value can only be caught at the end of the low phase.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int unsigned SYNC_SLOTS   = 33;
  localparam int unsigned RD_TX_BITS   = 16;
  localparam int unsigned WR_TX_BITS   = 32;
  localparam int unsigned RD_RX_SLOTS  = 19;
  localparam int unsigned WR_RX_SLOTS  = 2;
  localparam int unsigned RX_KEEP_LO   = 2;
  localparam int unsigned RX_KEEP_HI   = 17;
  localparam int unsigned IDX_W        = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_TX,
    ST_RX,
    ST_FIN
  } seq_state_e;

  // Read header, left aligned into a 32-bit shift word.
  function automatic logic [31:0] rd_frame_word(input logic [4:0] phy,
                                                input logic [4:0] regad);
    return {2'b11, 2'b01, 2'b10, phy, regad, 16'h0000};
  endfunction

  // Full write word: start, opcode, addresses, turnaround, data.
  function automatic logic [31:0] wr_frame_word(input logic [4:0] phy,
                                                input logic [4:0] regad,
                                                input logic [15:0] data);
    return {2'b01, 2'b01, phy, regad, 2'b10, data};
  endfunction

  // System cycles per MDC half period, rounded up so MDC never runs fast.
  function automatic int unsigned mdc_half_cycles(input int unsigned sys_hz,
                                                  input int unsigned max_hz);
    int unsigned h;
    h = (sys_hz + 2 * max_hz - 1) / (2 * max_hz);
    return (h == 0) ? 1 : h;
  endfunction

  // Released-slot index that carries a result bit.
  function automatic logic rx_slot_kept(input logic [IDX_W-1:0] idx);
    return (idx >= IDX_W'(RX_KEEP_LO)) && (idx <= IDX_W'(RX_KEEP_HI));
  endfunction

endpackage

// File: rtl/mdio_mdc_timer.sv
module mdio_mdc_timer #(
  parameter int unsigned HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic sample_tick,
  output logic slot_end
);
  localparam int unsigned SLOT = 2 * HALF;
  localparam int PH_W = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(SLOT - 1);

  logic [PH_W-1:0] phase;
  logic            mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      mdc_q <= 1'b0;
    end else if (!run) begin
      phase <= '0;
      mdc_q <= 1'b0;
    end else begin
      phase <= (phase == PH_LAST) ? '0 : phase + 1'b1;
      if (phase == PH_SAMPLE)
        mdc_q <= 1'b1;
      else if (phase == PH_LAST)
        mdc_q <= 1'b0;
    end
  end

  assign mdc         = mdc_q;
  assign sample_tick = run && (phase == PH_SAMPLE);
  assign slot_end    = run && (phase == PH_LAST);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             reject,
  input  logic             rd_in,
  input  logic [31:0]      frame_in,
  input  logic             slot_end,
  output seq_state_e       state,
  output logic [IDX_W-1:0] slot_idx,
  output logic             rd_mode,
  output logic             mdio_out,
  output logic             mdio_oe,
  output logic             frame_end
);
  logic [31:0]      shreg;
  logic [IDX_W-1:0] tx_last;
  logic [IDX_W-1:0] rx_last;

  assign tx_last   = rd_mode ? IDX_W'(RD_TX_BITS - 1) : IDX_W'(WR_TX_BITS - 1);
  assign rx_last   = rd_mode ? IDX_W'(RD_RX_SLOTS - 1) : IDX_W'(WR_RX_SLOTS - 1);
  assign frame_end = (state == ST_RX) && slot_end && (slot_idx == rx_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      slot_idx <= '0;
      rd_mode  <= 1'b0;
      shreg    <= '0;
      mdio_out <= 1'b0;
      mdio_oe  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (go) begin
            state    <= ST_SYNC;
            slot_idx <= '0;
            rd_mode  <= rd_in;
            shreg    <= frame_in;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b1;
          end else if (reject) begin
            state   <= ST_FIN;
            rd_mode <= rd_in;
          end
        end
        ST_SYNC: begin
          if (slot_end) begin
            if (slot_idx == IDX_W'(SYNC_SLOTS - 1)) begin
              state    <= ST_TX;
              slot_idx <= '0;
              mdio_out <= shreg[31];
            end else begin
              slot_idx <= slot_idx + 1'b1;
            end
          end
        end
        ST_TX: begin
          if (slot_end) begin
            shreg <= {shreg[30:0], 1'b0};
            if (slot_idx == tx_last) begin
              state    <= ST_RX;
              slot_idx <= '0;
              mdio_out <= 1'b0;
              mdio_oe  <= 1'b0;
            end else begin
              slot_idx <= slot_idx + 1'b1;
              mdio_out <= shreg[30];
            end
          end
        end
        ST_RX: begin
          if (slot_end) begin
            if (slot_idx == rx_last)
              state <= ST_FIN;
            else
              slot_idx <= slot_idx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_tick,
  input  logic             in_rx,
  input  logic [IDX_W-1:0] slot_idx,
  input  logic             mdio_in,
  input  logic             commit,
  input  logic             load_ones,
  output logic [15:0]      rdata
);
  logic [15:0] acc;
  logic        take_bit;

  assign take_bit = in_rx && sample_tick && rx_slot_kept(slot_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      rdata <= '0;
    end else begin
      if (take_bit)
        acc <= {acc[14:0], mdio_in};
      if (load_ones)
        rdata <= 16'hFFFF;
      else if (commit)
        rdata <= acc;
    end
  end

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 25_000_000,
  parameter int unsigned MDC_MAX_HZ = 2_500_000,
  parameter int unsigned REG_ADDR_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_start,
  input  logic                  req_write,
  input  logic [4:0]            req_phy,
  input  logic [REG_ADDR_W-1:0] req_reg,
  input  logic [15:0]           req_wdata,
  output logic [15:0]           rsp_rdata,
  output logic                  rsp_busy,
  output logic                  rsp_done,
  output logic                  mdc,
  output logic                  mdio_out,
  output logic                  mdio_oe,
  input  logic                  mdio_in
);
  localparam int unsigned MDC_HALF = mdc_half_cycles(SYS_CLK_HZ, MDC_MAX_HZ);

  seq_state_e       state;
  logic [IDX_W-1:0] slot_idx;
  logic             rd_mode;
  logic             frame_end;
  logic             sample_tick;
  logic             slot_end;
  logic             reg_ok;
  logic [31:0]      frame_word;

  // Named events for the checker.
  logic accept;
  logic go;
  logic reject;
  logic run;
  logic in_rx;
  logic commit;
  logic load_ones;

  generate
    if (REG_ADDR_W > 5) begin : g_wide_reg
      assign reg_ok = ~|req_reg[REG_ADDR_W-1:5];
    end else begin : g_narrow_reg
      assign reg_ok = 1'b1;
    end
  endgenerate

  assign frame_word = req_write ? wr_frame_word(req_phy, req_reg[4:0], req_wdata)
                                : rd_frame_word(req_phy, req_reg[4:0]);

  assign accept    = req_start && (state == ST_IDLE);
  assign go        = accept && reg_ok;
  assign reject    = accept && !reg_ok;
  assign run       = (state == ST_SYNC) || (state == ST_TX) || (state == ST_RX);
  assign in_rx     = (state == ST_RX);
  assign commit    = frame_end && rd_mode;
  assign load_ones = reject && !req_write;

  mdio_mdc_timer #(.HALF(MDC_HALF)) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .mdc         (mdc),
    .sample_tick (sample_tick),
    .slot_end    (slot_end)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .reject    (reject),
    .rd_in     (!req_write),
    .frame_in  (frame_word),
    .slot_end  (slot_end),
    .state     (state),
    .slot_idx  (slot_idx),
    .rd_mode   (rd_mode),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end)
  );

  mdio_rx_capture u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .in_rx       (in_rx),
    .slot_idx    (slot_idx),
    .mdio_in     (mdio_in),
    .commit      (commit),
    .load_ones   (load_ones),
    .rdata       (rsp_rdata)
  );

  assign rsp_busy = (state != ST_IDLE);
  assign rsp_done = (state == ST_FIN);

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int unsigned HALF  = 5,
  parameter int unsigned REG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_start,
  input logic [REG_W-1:0] req_reg,
  input logic             rsp_busy,
  input logic             rsp_done,
  input logic [15:0]      rsp_rdata,
  input logic             mdc,
  input logic             mdio_out,
  input logic             mdio_oe,
  input logic             in_rx
);
  logic        mdc_q;
  logic [15:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q   <= 1'b0;
      run_len <= '0;
    end else begin
      mdc_q   <= mdc;
      run_len <= (mdc != mdc_q) ? 16'd1 :
                 ((run_len == 16'hFFFF) ? run_len : run_len + 16'd1);
    end
  end

  p_mdc_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_busy |-> !mdc);

  p_mdc_high_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && !mdc) |-> (run_len == 16'(HALF)));

  p_mdc_low_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mdc_q && mdc) |-> (run_len >= 16'(HALF)));

  p_out_stable_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> ($stable(mdio_out) && $stable(mdio_oe)));

  p_refuse_quick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !rsp_busy && (req_reg > REG_W'(31))) |=> (rsp_done && !mdc && !mdio_oe));

  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_start && !rsp_busy && (req_reg <= REG_W'(31))) |=> (rsp_busy && !rsp_done));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_done_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> rsp_busy);

  p_oe_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rx || !rsp_busy) |-> !mdio_oe);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_done);

endmodule

bind mdio_master mdio_master_chk #(
  .HALF  (MDC_HALF),
  .REG_W (REG_ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_start (req_start),
  .req_reg   (req_reg),
  .rsp_busy  (rsp_busy),
  .rsp_done  (rsp_done),
  .rsp_rdata (rsp_rdata),
  .mdc       (mdc),
  .mdio_out  (mdio_out),
  .mdio_oe   (mdio_oe),
  .in_rx     (in_rx)
);

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_EXP   = 5;              // 25 MHz / (2 * 2.5 MHz)
  localparam int RD_CYC     = 68 * 2 * HALF_EXP;
  localparam int WR_CYC     = 67 * 2 * HALF_EXP;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [5:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] rsp_rdata;
  logic        rsp_busy, rsp_done, mdc, mdio_out, mdio_oe, mdio_in;

  int n_chk = 0;
  int n_fail = 0;

  // Monitors
  int          rises, drv_n, rel_n, done_n, oe_cyc, out_viol, hi_run, hi_min, hi_max;
  logic [95:0] drv_bits;
  logic        prev_mdc = 1'b0, prev_out = 1'b0;
  logic        phy_reply = 1'b0;
  logic [15:0] phy_word = '0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_busy(rsp_busy), .rsp_done(rsp_done),
    .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  // PHY model: the value for slot s is presented right after the s-th MDC rise.
  function automatic logic phy_bit(input int s);
    int k;
    if (!phy_reply || s < 49) return 1'b1;
    k = s - 49;
    if (k == 1) return 1'b0;
    if (k >= 2 && k <= 17) return phy_word[17 - k];
    return 1'b1;
  endfunction

  assign mdio_in = phy_bit(rises);

  always @(posedge mdc) begin
    if (mdio_oe) begin
      drv_bits = {drv_bits[94:0], mdio_out};
      drv_n++;
    end else begin
      rel_n++;
    end
    rises++;
  end

  always @(negedge clk) begin
    if (rsp_done) done_n++;
    if (mdio_oe) oe_cyc++;
    if (mdc && (mdio_out !== prev_out)) out_viol++;
    if (mdc) hi_run++;
    else if (prev_mdc) begin
      if (hi_run < hi_min) hi_min = hi_run;
      if (hi_run > hi_max) hi_max = hi_run;
      hi_run = 0;
    end
    prev_mdc = mdc;
    prev_out = mdio_out;
  end

  task automatic clear_mon();
    rises = 0; drv_n = 0; rel_n = 0; done_n = 0; oe_cyc = 0;
    out_viol = 0; hi_run = 0; hi_min = 1000000; hi_max = 0; drv_bits = '0;
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic launch(input bit wr, input logic [4:0] phy, input logic [5:0] regad,
                        input logic [15:0] wd, output int cyc, output bit busy_after);
    @(negedge clk);
    req_write = wr; req_phy = phy; req_reg = regad; req_wdata = wd;
    req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    busy_after = rsp_busy;
    cyc = 0;
    while (!rsp_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic after_done();
    @(negedge clk);
    chk(!rsp_busy, "R9", "busy after done", rsp_busy, 0);
    chk(done_n == 1, "R9", "done pulses", done_n, 1);
    chk(!mdc && !mdio_oe, "R1", "bus idle after frame", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_read(input logic [4:0] phy, input logic [5:0] regad, input logic [15:0] d);
    int cyc; bit b; logic [15:0] hdr;
    hdr = 16'hD800 | (16'(phy) << 5) | 16'(regad[4:0]);
    phy_word = d; phy_reply = 1'b1;
    clear_mon();
    launch(1'b0, phy, regad, 16'h0, cyc, b);
    chk(b, "R9", "busy after accept", b, 1);
    chk(cyc == RD_CYC, "R12", "read cycles", cyc, RD_CYC);
    chk(rsp_rdata == d, "R4", "read data", rsp_rdata, d);
    chk(drv_n == 49, "R10", "read driven slots", drv_n, 49);
    chk(drv_bits[48:16] == {33{1'b1}}, "R2", "sync run", drv_bits[48:16], 33'h1FFFFFFFF);
    chk(drv_bits[15:0] == hdr, "R3", "read header", drv_bits[15:0], hdr);
    chk(rel_n == 19, "R4", "released slots", rel_n, 19);
    chk(hi_min == HALF_EXP && hi_max == HALF_EXP, "R1", "mdc high len", hi_max, HALF_EXP);
    chk(out_viol == 0, "R7", "mdio change while mdc high", out_viol, 0);
    after_done();
  endtask

  task automatic t_write(input logic [4:0] phy, input logic [5:0] regad, input logic [15:0] d);
    int cyc; bit b; logic [31:0] word; logic [15:0] held;
    word = 32'h5002_0000 | (32'(phy) << 23) | (32'(regad[4:0]) << 18) | 32'(d);
    held = rsp_rdata;
    phy_reply = 1'b0;
    clear_mon();
    launch(1'b1, phy, regad, d, cyc, b);
    chk(b, "R9", "busy after accept", b, 1);
    chk(cyc == WR_CYC, "R12", "write cycles", cyc, WR_CYC);
    chk(drv_n == 65, "R10", "write driven slots", drv_n, 65);
    chk(drv_bits[64:32] == {33{1'b1}}, "R2", "sync run", drv_bits[64:32], 33'h1FFFFFFFF);
    chk(drv_bits[31:0] == word, "R5", "write word", drv_bits[31:0], word);
    chk(rel_n == 2, "R6", "released after write", rel_n, 2);
    chk(out_viol == 0, "R7", "mdio change while mdc high", out_viol, 0);
    chk(rsp_rdata == held, "R11", "rdata across write", rsp_rdata, held);
    after_done();
  endtask

  task automatic t_refused(input bit wr, input logic [5:0] regad);
    int cyc; bit b; logic [15:0] held; logic [15:0] exp;
    held = rsp_rdata;
    exp = wr ? held : 16'hFFFF;
    clear_mon();
    launch(wr, 5'd3, regad, 16'h1357, cyc, b);
    chk(cyc == 0, "R8", "refused done delay", cyc, 0);
    chk(rises == 0 && oe_cyc == 0, "R8", "bus untouched", rises + oe_cyc, 0);
    chk(rsp_rdata == exp, "R8", "refused rdata", rsp_rdata, exp);
    after_done();
  endtask

  task automatic t_busy_ignore();
    int cyc; logic [15:0] hdr;
    hdr = 16'hD800 | (16'd7 << 5) | 16'd2;
    phy_word = 16'h0F0F; phy_reply = 1'b1;
    clear_mon();
    @(negedge clk);
    req_write = 1'b0; req_phy = 5'd7; req_reg = 6'd2; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    repeat (99) @(negedge clk);
    req_write = 1'b1; req_phy = 5'd9; req_reg = 6'd5; req_wdata = 16'hAAAA; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    cyc = 100;
    while (!rsp_done && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == RD_CYC, "R9", "second start ignored, timing", cyc, RD_CYC);
    chk(drv_n == 49 && drv_bits[15:0] == hdr, "R9", "frame kept as read", drv_bits[15:0], hdr);
    chk(rsp_rdata == 16'h0F0F, "R4", "read data", rsp_rdata, 16'h0F0F);
    after_done();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mdc && !mdio_oe && !rsp_busy && !rsp_done, "R1", "reset outputs",
        {mdc, mdio_oe, rsp_busy, rsp_done}, 0);
    chk(rsp_rdata == 16'h0, "R11", "reset rdata", rsp_rdata, 0);
    t_read(5'd1, 6'd1, 16'hA5C3);
    t_write(5'h12, 6'd4, 16'h01E1);
    t_read(5'd31, 6'd31, 16'h0001);
    t_read(5'd0, 6'd0, 16'h8000);
    t_refused(1'b0, 6'd32);
    t_read(5'd20, 6'd17, 16'h1234);
    t_refused(1'b1, 6'd63);
    t_write(5'd0, 6'd0, 16'hFFFF);
    t_busy_ignore();
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end

endmodule